// File: doc/BRIEF.md
# Timer Compare-Output Generator

This block pairs a free-running period counter with a single compare channel and produces a registered output level that downstream output logic can drive onto a pin. The counter runs between zero and a programmable reload value, either upward or downward. Each enabled clock it compares the count against a programmable threshold. A 3-bit mode field then decides what the prepared level does. It can react to an exact match (hold, set, clear, toggle), be forced to a fixed level, or follow the count as a PWM waveform of either polarity.

The reload and threshold inputs act in the very cycle they change; there is no shadow copy. Two one-cycle flags accompany the level: one reports a match between count and threshold, the other reports that the counter has wrapped. All three outputs are registered. Each reflects the count value held during the previous enabled cycle.

Top module: `cmp_out_gen`

## Requirements
- R1: Counting upward (down_i=0), the counter steps 0,1,...,reload_i and then returns to 0, giving a period of reload_i+1 enabled clocks. A count at or above reload_i returns to 0 on the next enabled clock, so a lowered reload_i acts at once.
- R2: Counting downward (down_i=1), the counter steps reload_i,...,1,0 and then reloads reload_i. A count above reload_i also reloads at once. The period is again reload_i+1 enabled clocks.
- R3: ovf_o is high for exactly the one cycle after each enabled clock on which the counter wrapped (up: returned to 0; down: reloaded).
- R4: match_o is high for exactly the one cycle after each enabled clock on which the count equalled cmp_i.
- R5: Mode encodings on mode_i: 3'b000 keeps the level on a match, 3'b001 sets it to 1 on a match, and 3'b010 clears it to 0 on a match. Without a match, all three keep the level.
- R6: Mode 3'b011 inverts the level on each match and keeps it otherwise.
- R7: Mode 3'b100 drives the level to 0 and mode 3'b101 drives it to 1 on every enabled clock.
- R8: Mode 3'b110 (positive PWM) sets the level to 1 when count < cmp_i while counting up, and when count <= cmp_i while counting down. Otherwise it sets the level to 0. Mode 3'b111 gives the inverse level.
- R9: In mode 3'b110, cmp_i > reload_i holds the level at 1 in both directions, and cmp_i = 0 holds it at 0 in both directions. In mode 3'b111 the opposite levels hold.
- R10: While cnt_en_i=0 the counter and prep_o keep their values and match_o and ovf_o stay 0.
- R11: While rst_ni is low the counter, prep_o, match_o and ovf_o are 0.
- R12: Every output changes only on a rising clock edge, one clock after the count value it was derived from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter and channel enable |
| down_i | input | 1 | Count direction: 0 up, 1 down |
| reload_i | input | CNT_W | Reload (top count) value |
| cmp_i | input | CNT_W | Compare threshold |
| mode_i | input | 3 | Output mode select |
| prep_o | output | 1 | Prepared output level |
| match_o | output | 1 | One-cycle compare match flag |
| ovf_o | output | 1 | One-cycle wrap flag |

## Verification
The bench targets the PWM extremes, where cmp_i is zero or larger than reload_i. An off-by-one comparison there would leak a one-cycle glitch into what should be a flat level. This matters most when counting down, where a naive <= test would fire once per period with cmp_i at zero. It also lowers reload_i below the current count. An equality-only wrap test would then run the counter through the full range, and no ovf_o would appear for thousands of cycles. Randomly gated enables catch a design that keeps counting or leaves a flag high while disabled. Toggle mode checks that a match inverts the level exactly once per period rather than holding or double-flipping it.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD    = 3'b000,
    MODE_SET     = 3'b001,
    MODE_CLR     = 3'b010,
    MODE_TGL     = 3'b011,
    MODE_FLO     = 3'b100,
    MODE_FHI     = 3'b101,
    MODE_PWM_POS = 3'b110,
    MODE_PWM_NEG = 3'b111
  } cmp_mode_e;
endpackage

// File: rtl/cmp_counter.sv
module cmp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         down_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  always_comb begin
    if (down_i) begin
      wrap  = (cnt_q == '0) || (cnt_q > reload_i);
      cnt_d = wrap ? reload_i : cnt_q - ONE;
    end else begin
      // >= so a lowered reload takes effect without running the full range
      wrap  = (cnt_q >= reload_i);
      cnt_d = wrap ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;

  assert_up_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !down_i && cnt_q < reload_i) |=> cnt_q == $past(cnt_q) + ONE);
  assert_up_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !down_i && cnt_q >= reload_i) |=> cnt_q == '0);
  assert_dn_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && down_i && cnt_q != '0 && cnt_q <= reload_i) |=> cnt_q == $past(cnt_q) - ONE);
  assert_dn_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && down_i && (cnt_q == '0 || cnt_q > reload_i)) |=> cnt_q == $past(reload_i));
  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_level_dec.sv
module cmp_level_dec
  import cmp_out_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [2:0]   mode_i,
  input  logic         down_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         level_q_i,
  output logic         eq_o,
  output logic         level_d_o
);
  cmp_mode_e mode;
  logic      pwm_act;

  assign mode = cmp_mode_e'(mode_i);
  assign eq_o = (cnt_i == cmp_i);

  // zero threshold saturates inactive in both directions
  always_comb begin
    if (down_i) pwm_act = (cmp_i != '0) && (cnt_i <= cmp_i);
    else        pwm_act = (cnt_i < cmp_i);
  end

  always_comb begin
    level_d_o = level_q_i;
    unique case (mode)
      MODE_HOLD:    level_d_o = level_q_i;
      MODE_SET:     if (eq_o) level_d_o = 1'b1;
      MODE_CLR:     if (eq_o) level_d_o = 1'b0;
      MODE_TGL:     if (eq_o) level_d_o = ~level_q_i;
      MODE_FLO:     level_d_o = 1'b0;
      MODE_FHI:     level_d_o = 1'b1;
      MODE_PWM_POS: level_d_o = pwm_act;
      MODE_PWM_NEG: level_d_o = ~pwm_act;
      default:      level_d_o = level_q_i;
    endcase
  end
endmodule

// File: rtl/cmp_out_reg.sv
module cmp_out_reg
  import cmp_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       eq_i,
  input  logic       wrap_i,
  input  logic       level_d_i,
  output logic       level_q_o,
  output logic       match_o,
  output logic       ovf_o
);
  logic level_q, match_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      match_q <= en_i & eq_i;
      ovf_q   <= en_i & wrap_i;
      if (en_i) level_q <= level_d_i;
    end
  end

  assign level_q_o = level_q;
  assign match_o   = match_q;
  assign ovf_o     = ovf_q;

  assert_ovf_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_i) |=> ovf_q);
  assert_match_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && eq_i) |=> match_q);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_HOLD) |=> level_q == $past(level_q));
  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_SET && eq_i) |=> level_q);
  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_CLR && eq_i) |=> !level_q);
  assert_tgl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_TGL && eq_i) |=> level_q != $past(level_q));
  assert_force_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_FHI) |=> level_q);
  assert_force_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_FLO) |=> !level_q);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!match_q && !ovf_q && level_q == $past(level_q)));
endmodule

// File: rtl/cmp_out_gen.sv
module cmp_out_gen
  import cmp_out_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [2:0]       mode_i,
  output logic             prep_o,
  output logic             match_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap, eq, level_d, level_q;

  cmp_counter #(.W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .down_i   (down_i),
    .reload_i (reload_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  cmp_level_dec #(.W(CNT_W)) u_level_dec (
    .mode_i    (mode_i),
    .down_i    (down_i),
    .cnt_i     (cnt),
    .cmp_i     (cmp_i),
    .level_q_i (level_q),
    .eq_o      (eq),
    .level_d_o (level_d)
  );

  cmp_out_reg u_out_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .mode_i    (mode_i),
    .eq_i      (eq),
    .wrap_i    (wrap),
    .level_d_i (level_d),
    .level_q_o (level_q),
    .match_o   (match_o),
    .ovf_o     (ovf_o)
  );

  assign prep_o = level_q;

  assert_sat_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && mode_i == MODE_PWM_POS && cmp_i > reload_i && cnt <= reload_i) |=> prep_o);
  assert_sat_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && mode_i == MODE_PWM_POS && cmp_i == '0) |=> !prep_o);
  assert_pwm_inv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && mode_i == MODE_PWM_NEG && !down_i && cnt < cmp_i) |=> !prep_o);
endmodule

// File: tb/cmp_out_gen_bench.sv
`timescale 1ns/1ps
module cmp_out_gen_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, down = 1'b0;
  logic [W-1:0] reload = '0, cmp = '0;
  logic [2:0]   mode = 3'b000;
  logic         prep, match, ovf;

  int    n_chk = 0, n_bad = 0, cyc = 0, ovf_seen = 0, match_seen = 0;
  int    m_cnt = 0;
  bit    m_prep = 0, m_match = 0, m_ovf = 0, cmp_on = 0;
  string tag = "R11";

  always #4 clk = ~clk;

  cmp_out_gen #(.CNT_W(W)) u_cmp_out_gen (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .down_i(down),
    .reload_i(reload), .cmp_i(cmp), .mode_i(mode),
    .prep_o(prep), .match_o(match), .ovf_o(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    int  c, r, k;
    bit  hit, wr, act;
    if (!rst_n) begin
      m_cnt = 0; m_prep = 0; m_match = 0; m_ovf = 0;
    end else if (!en) begin
      m_match = 0; m_ovf = 0;
    end else begin
      c = m_cnt; r = int'(reload); k = int'(cmp);
      hit = (c == k);
      if (down) begin
        wr = (c == 0) || (c > r);
        m_cnt = wr ? r : c - 1;
        act = (k != 0) && (c <= k);
      end else begin
        wr = (c >= r);
        m_cnt = wr ? 0 : c + 1;
        act = (c < k);
      end
      case (mode)
        3'b001: if (hit) m_prep = 1;
        3'b010: if (hit) m_prep = 0;
        3'b011: if (hit) m_prep = !m_prep;
        3'b100: m_prep = 0;
        3'b101: m_prep = 1;
        3'b110: m_prep = act;
        3'b111: m_prep = !act;
        default: ;
      endcase
      m_match = hit; m_ovf = wr;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag, int'(prep), int'(m_prep));
      check("R4 match", int'(match), int'(m_match));
      check("R3 ovf", int'(ovf), int'(m_ovf));
      if (ovf) ovf_seen++;
      if (match) match_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run(input string t, input bit e, input bit d, input int rl,
                     input int cv, input logic [2:0] md, input int n);
    @(negedge clk);
    tag = t; en = e; down = d; reload = W'(rl); cmp = W'(cv); mode = md;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 prep", int'(prep), 0);
    check("R11 match", int'(match), 0);
    check("R11 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // R1 period: exactly one wrap per reload+1 cycles
    run("R1", 1, 0, 9, 4, 3'b110, 12);
    ovf_seen = 0; match_seen = 0;
    repeat (50) @(negedge clk);
    check("R1 wraps", ovf_seen, 5);
    check("R4 matches", match_seen, 5);
    run("R8 pwm pos up", 1, 0, 9, 4, 3'b110, 30);
    run("R8 pwm neg up", 1, 0, 9, 4, 3'b111, 30);
    run("R9 sat hi up", 1, 0, 9, 12, 3'b110, 30);
    run("R9 sat lo up", 1, 0, 9, 0, 3'b110, 30);
    run("R9 neg sat up", 1, 0, 9, 0, 3'b111, 30);
    // R2 period when counting down
    run("R2", 1, 1, 7, 3, 3'b110, 12);
    ovf_seen = 0;
    repeat (40) @(negedge clk);
    check("R2 wraps", ovf_seen, 5);
    run("R8 pwm pos down", 1, 1, 7, 3, 3'b110, 30);
    run("R8 pwm neg down", 1, 1, 7, 3, 3'b111, 30);
    run("R9 sat lo down", 1, 1, 7, 0, 3'b110, 30);
    run("R9 sat hi down", 1, 1, 7, 9, 3'b110, 30);
    run("R9 sat top eq", 1, 0, 7, 7, 3'b110, 30);
    // match-driven modes
    run("R7 force hi", 1, 0, 5, 2, 3'b101, 8);
    run("R5 hold", 1, 0, 5, 2, 3'b000, 20);
    run("R5 clear", 1, 0, 5, 2, 3'b010, 20);
    run("R5 set", 1, 0, 5, 3, 3'b001, 20);
    run("R6 toggle up", 1, 0, 5, 3, 3'b011, 30);
    run("R6 toggle down", 1, 1, 5, 0, 3'b011, 30);
    run("R7 force lo", 1, 1, 5, 0, 3'b100, 8);
    // R1: reload lowered below running count
    run("R1 big", 1, 0, 2000, 1000, 3'b110, 500);
    run("R1 shrink", 1, 0, 20, 10, 3'b110, 5);
    ovf_seen = 0;
    repeat (42) @(negedge clk);
    check("R1 shrink wraps", ovf_seen, 2);
    run("R2 shrink", 1, 1, 6, 3, 3'b110, 3);
    run("R2 big", 1, 0, 300, 150, 3'b011, 250);
    run("R2 shrink down", 1, 1, 9, 5, 3'b110, 40);
    // R10: gated enable, R12 registered timing covered by every compare
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tag = "R10 gated";
      en = 1'($urandom_range(0, 1));
      if (i % 100 == 0) begin
        mode = 3'($urandom_range(0, 7));
        down = 1'($urandom_range(0, 1));
      end
      reload = W'(11); cmp = W'(5);
    end
    run("R10 idle", 0, 0, 11, 5, 3'b011, 20);
    check("R10 idle match", int'(match), 0);
    check("R10 idle ovf", int'(ovf), 0);
    run("R12 mixed", 1, 0, 3, 1, 3'b110, 40);
    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule